// File: doc/BRIEF.md
# Addressable Latch Bank with Demultiplexer Mode

This block holds eight single-bit values in level-sensitive storage cells. A 3-bit select picks one cell, and a single data bit is written into it. Two active-low controls, a clear and an enable, choose one of four modes:

- **Latch:** the selected cell is transparent to the data bit and the others keep their contents.
- **Hold:** every cell holds and ignores data and select.
- **Demultiplexer:** the selected output passes the data bit and every other output is forced low.
- **Clear:** all outputs are forced low.

The block has no clock. Every output is the content of its storage cell and changes as soon as the inputs that control it change. The select lines should only move while the enable is inactive. If they move while the enable is active, a passing address can load the data bit into a cell that was not meant to be written. Wider words are built outside the block by giving each bank its own enable.

Top module: `addr_latch_bank`

## Requirements
- R1: With clr_n high and en_n low, output q[sel] follows din while en_n stays low, and keeps the last value when en_n rises.
- R2: In the latch mode of R1, every output other than q[sel] keeps its previous value.
- R3: With clr_n high and en_n high, all outputs keep their values whatever din and sel do.
- R4: With clr_n low and en_n low, q[sel] equals din and every other output is 0.
- R5: With clr_n low and en_n high, all eight outputs are 0 whatever din and sel are.
- R6: sel is an unsigned binary index with sel[2] as the most significant bit. Index k addresses q[k], so sel = 3'b101 addresses q[5].
- R7: On leaving the demultiplexer mode for the hold mode (clr_n rises first, then en_n rises), the addressed output keeps the last din and every other output reads 0.
- R8: Clear takes effect with no clock. Outputs go to 0 within the same time step in which clr_n falls with en_n high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr_n | input | 1 | Active-low clear; together with en_n selects the mode |
| en_n | input | 1 | Active-low enable for the addressed cell |
| sel | input | 3 | Binary index of the addressed cell |
| din | input | 1 | Data bit written to or passed through the addressed cell |
| q | output | 8 | Parallel contents of the eight cells |

## Verification
The assertions re-check the static modes whenever an input or output changes:
- in clear mode, all outputs are 0;
- in demultiplexer mode, the output word is din shifted to position sel, and exactly din outputs are set;
- in latch mode, the addressed output equals din;
- the address decode is one-hot.

Some behaviour depends on what the cells held before, and only the bench scenarios can show it. This covers:
- hold mode ignoring sweeps of data and select;
- unaddressed cells keeping their contents through a walk of writes;
- the contents left behind after demultiplexer mode;
- clear taking effect with no clock edge.

// File: rtl/addr_latch_pkg.sv
// Package: shared mode type for the addressable latch bank.
// Assumes the clear/enable pair is the only mode source.
package addr_latch_pkg;
    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } bank_mode_e;
endpackage

// File: rtl/latch_mode_decode.sv
// Module: maps the active-low clear/enable pair onto one of four modes.
// Assumes both inputs are already settled levels; purely combinational.
module latch_mode_decode
    import addr_latch_pkg::*;
(
    input  logic       clr_n,
    input  logic       en_n,
    output bank_mode_e mode_o
);
    // Purpose: select the mode from the two control levels.
    always_comb begin
        unique case ({clr_n, en_n})
            2'b10:   mode_o = MODE_LATCH;
            2'b11:   mode_o = MODE_HOLD;
            2'b00:   mode_o = MODE_DEMUX;
            default: mode_o = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/latch_addr_decode.sv
// Module: binary-to-one-hot decoder for the cell select.
// Assumes sel is unsigned with its top bit most significant.
module latch_addr_decode #(
    parameter int SEL_W = 3,
    localparam int N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     hit_o
);
    for (genvar i = 0; i < N; i++) begin : g_hit
        // Purpose: raise the hit line of cell i when the index matches.
        assign hit_o[i] = (sel == SEL_W'(i));
    end

    // Purpose: a settled select must address exactly one cell.
    always_comb begin
        if (!$isunknown(sel)) begin
            // R6
            onehot_hit_chk: assert ($onehot(hit_o))
                else $error("address decode not one-hot");
        end
    end
endmodule

// File: rtl/latch_bit_cell.sv
// Module: one level-sensitive storage bit with a dominant clear.
// Assumes clr_i and wr_i come from glitch-free mode logic upstream.
module latch_bit_cell (
    input  logic clr_i,
    input  logic wr_i,
    input  logic d_i,
    output logic q_o
);
    // Purpose: clear dominates; otherwise transparent while wr_i is high.
    always_latch begin
        if (clr_i)
            q_o = 1'b0;
        else if (wr_i)
            q_o = d_i;
    end
endmodule

// File: rtl/addr_latch_bank.sv
// Module: eight addressable storage bits with latch, hold, demux and clear modes.
// Assumes en_n is held high while sel changes; contents are undefined until
// the first clear.
module addr_latch_bank
    import addr_latch_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int N = 1 << SEL_W
) (
    input  logic             clr_n,
    input  logic             en_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    output logic [N-1:0]     q
);
    bank_mode_e mode;
    logic [N-1:0] hit;
    logic [N-1:0] cell_clr;
    logic [N-1:0] cell_wr;

    latch_mode_decode i_mode (
        .clr_n  (clr_n),
        .en_n   (en_n),
        .mode_o (mode)
    );

    latch_addr_decode #(.SEL_W(SEL_W)) i_addr (
        .sel   (sel),
        .hit_o (hit)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        // Purpose: clear the cell in clear mode, or in demux mode when unaddressed.
        assign cell_clr[i] = (mode == MODE_CLEAR) || ((mode == MODE_DEMUX) && !hit[i]);
        // Purpose: open the addressed cell in latch and demux modes.
        assign cell_wr[i]  = hit[i] && ((mode == MODE_LATCH) || (mode == MODE_DEMUX));

        latch_bit_cell i_cell (
            .clr_i (cell_clr[i]),
            .wr_i  (cell_wr[i]),
            .d_i   (din),
            .q_o   (q[i])
        );
    end

    // Purpose: compare the output word against the port-level mode rules.
    always_comb begin
        if (!$isunknown({clr_n, en_n, sel, din})) begin
            if (!clr_n && en_n) begin
                // R5
                clear_zero_chk: assert (q == '0)
                    else $error("clear mode output not zero");
            end
            if (!clr_n && !en_n) begin
                // R4
                demux_word_chk: assert (q == (N'(din) << sel))
                    else $error("demux output word wrong");
                // R4
                demux_count_chk: assert ($countones(q) == int'(din))
                    else $error("demux output count wrong");
            end
            if (clr_n && !en_n) begin
                // R1
                latch_follow_chk: assert (q[sel] == din)
                    else $error("addressed cell not transparent");
            end
        end
    end
endmodule

// File: tb/test_addr_latch_bank.sv
module test_addr_latch_bank;
    logic       clk = 1'b0;
    logic       clr_n, en_n, din;
    logic [2:0] sel;
    logic [7:0] q;
    logic [7:0] model;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    addr_latch_bank i_addr_latch_bank (
        .clr_n (clr_n),
        .en_n  (en_n),
        .sel   (sel),
        .din   (din),
        .q     (q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic e, input logic [2:0] s, input logic d);
        clr_n = c; en_n = e; sel = s; din = d;
        #5;
    endtask

    // Latch-mode write: address moves only while enable is inactive.
    task automatic write_cell(input logic [2:0] s, input logic d);
        drive(1'b1, 1'b1, s, din);
        drive(1'b1, 1'b0, s, d);
        check("R1", {7'b0, q[s]}, {7'b0, d});
        drive(1'b1, 1'b1, s, d);
        model[s] = d;
    endtask

    task automatic t_clear;
        for (int k = 0; k < 8; k++) begin
            drive(1'b0, 1'b1, 3'(k), k[0]);
            check("R5", q, 8'h00);
        end
        model = 8'h00;
    endtask

    task automatic t_latch_walk;
        for (int k = 0; k < 8; k++) begin
            write_cell(3'(k), k[0] ^ k[1]);
            check("R2", q, model);
        end
        for (int k = 7; k >= 0; k--) begin
            write_cell(3'(k), ~model[k]);
            check("R2", q, model);
        end
        drive(1'b0, 1'b1, 3'd0, 1'b0);
        model = 8'h00;
        write_cell(3'b101, 1'b1);
        check("R6", q, 8'b0010_0000);
        write_cell(3'b010, 1'b1);
        check("R6", q, 8'b0010_0100);
    endtask

    task automatic t_hold;
        write_cell(3'd0, 1'b1);
        for (int k = 0; k < 16; k++) begin
            drive(1'b1, 1'b1, 3'(k), k[3]);
            check("R3", q, model);
        end
    endtask

    task automatic t_demux;
        for (int k = 0; k < 8; k++) begin
            for (int d = 0; d < 2; d++) begin
                drive(1'b1, 1'b1, 3'(k), 1'(d));
                drive(1'b0, 1'b0, 3'(k), 1'(d));
                check("R4", q, 8'(d) << k);
            end
        end
    endtask

    task automatic t_demux_to_hold(input logic [2:0] s, input logic d);
        drive(1'b0, 1'b1, s, d);
        drive(1'b0, 1'b0, s, d);
        drive(1'b1, 1'b0, s, d);
        drive(1'b1, 1'b1, s, d);
        check("R7", q, 8'(d) << s);
        drive(1'b1, 1'b1, s + 3'd1, ~d);
        check("R7", q, 8'(d) << s);
    endtask

    task automatic t_async_clear;
        for (int k = 0; k < 8; k++) write_cell(3'(k), 1'b1);
        check("R1", q, 8'hFF);
        @(posedge clk);
        #3;
        clr_n = 1'b0;
        #1;
        check("R8", q, 8'h00);
        drive(1'b1, 1'b1, 3'd0, 1'b0);
        check("R8", q, 8'h00);
    endtask

    initial begin
        drive(1'b1, 1'b1, 3'd0, 1'b0);
        t_clear;
        t_latch_walk;
        t_hold;
        t_demux;
        t_demux_to_hold(3'd3, 1'b1);
        t_demux_to_hold(3'd6, 1'b0);
        t_demux_to_hold(3'd7, 1'b1);
        t_async_clear;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: q=%b expected %b", q, model);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule